// File: doc/BRIEF.md
# Phase Accumulator Square-Wave Synthesizer

This block produces a square wave whose frequency is a whole multiple N of a fixed step. A wide phase register gains the tuning word on every system clock. The output is high while the register is in the upper half of its range. Over time the output therefore toggles at f_clk × N / M, where M is the register modulus. The edges land on system-clock edges, so the timing uncertainty of any edge is at most one clock period.

A compile-time switch picks between two forms of the register. The binary form is a 20-bit register with modulus 2^20. The decimal form is a chain of 4-bit BCD digits with modulus 10^digits, which gives an exact step from a round-number clock such as 256 MHz or 100 MHz.

The tuning word is always given as an unsigned binary integer. A load strobe captures it. A new word changes the rate of the phase register but does not reset it, so the output phase stays continuous across retuning.

Top module: `phase_synth`

## Requirements
- R1: While the synchronous reset is high, the phase register and the held tuning word are cleared, so one cycle later the output is low.
- R2: Binary form (DECIMAL=0): on every clock without reset the phase register becomes (phase + tuning word) mod 2^20, and the output is bit 19 of the register, i.e. high when phase ≥ 2^19.
- R3: Decimal form (DECIMAL=1, DIGITS=6): the register holds six BCD digits, least significant digit in bits [3:0]. A digit that passes 9 wraps and carries one into the next digit, and the carry out of the top digit is dropped. The phase advances modulo 10^6, and the output is high when the top digit is 5 or more (phase ≥ 500000).
- R4: When tune_load is high at a clock edge, tune_in is captured at that edge and is added from the following edge on. Loading never clears the phase register.
- R5: When tune_load is low, changes on tune_in have no effect on the output.
- R6: tune_in is a 10-bit unsigned binary integer; in decimal form it is converted to its decimal digits before it is added, so a word of 1000 steps the phase by exactly one thousand.
- R7: The output falls exactly when the phase register wraps past its modulus, so over a window the output shows one rising edge per M/N clocks on average.
- R8: After reset and before any load, the held tuning word is zero and the output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_in | input | 10 | Tuning word N, unsigned binary |
| tune_load | input | 1 | Captures tune_in at the clock edge |
| synth_out | output | 1 | Synthesized square wave |

## Verification
The output comes straight from the phase register, so a change at the inputs shows up at the output only after two edges. The edge that samples tune_load captures the word, and the next edge is the first one that adds it. A reset at an edge shows as a low output right after that edge. The reference model follows this pipeline edge by edge and updates its held word only after it has used the old one. Each comparison is taken two nanoseconds after the edge that produced the expected value, and the next inputs are driven after that comparison.

// File: rtl/pas_pkg.sv
package pas_pkg;

  // Add two BCD digits with carry-in; result {carry_out, digit}.
  function automatic logic [4:0] bcd_digit_add(input logic [3:0] a,
                                               input logic [3:0] b,
                                               input logic       cin);
    logic [4:0] s;
    s = {1'b0, a} + {1'b0, b} + {4'b0, cin};
    if (s > 5'd9) return {1'b1, 4'(s - 5'd10)};
    else          return {1'b0, s[3:0]};
  endfunction

  // Binary to packed BCD (up to 16 digits) by shift-and-add-three.
  function automatic logic [63:0] bin_to_bcd(input logic [31:0] bin);
    logic [63:0] bcd;
    bcd = '0;
    for (int i = 31; i >= 0; i--) begin
      for (int d = 0; d < 16; d++) begin
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      end
      bcd = {bcd[62:0], bin[i]};
    end
    return bcd;
  endfunction

  // Packed BCD back to an integer value (used by the checker).
  function automatic longint bcd_value(input logic [63:0] bcd);
    longint v;
    v = 0;
    for (int d = 15; d >= 0; d--) v = v * 10 + longint'(bcd[4*d +: 4]);
    return v;
  endfunction

endpackage

// File: rtl/pas_tune_reg.sv
module pas_tune_reg #(
  parameter int TUNE_W  = 10,
  parameter int ACC_W   = 20,
  parameter bit DECIMAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [TUNE_W-1:0] tune_in,
  output logic [ACC_W-1:0]  addend
);
  logic [ACC_W-1:0] conv;

  generate
    if (DECIMAL) begin : g_dec
      always_comb conv = ACC_W'(pas_pkg::bin_to_bcd(32'(tune_in)));
    end else begin : g_bin
      always_comb conv = ACC_W'(tune_in);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       addend <= '0;
    else if (load) addend <= conv;
  end
endmodule

// File: rtl/pas_bin_acc.sv
module pas_bin_acc #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc,
  output logic         wrap
);
  logic [W:0] sum;
  always_comb sum = {1'b0, acc} + {1'b0, addend};
  assign wrap = sum[W];

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= sum[W-1:0];
  end
endmodule

// File: rtl/pas_dec_acc.sv
module pas_dec_acc #(
  parameter int DIGITS = 6,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc,
  output logic         wrap
);
  logic [DIGITS:0] carry;
  logic [W-1:0]    nxt;

  assign carry[0] = 1'b0;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [4:0] res;
      assign res          = pas_pkg::bcd_digit_add(acc[4*d +: 4], addend[4*d +: 4], carry[d]);
      assign carry[d+1]   = res[4];
      assign nxt[4*d +: 4] = res[3:0];
    end
  endgenerate

  assign wrap = carry[DIGITS];

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= nxt;
  end
endmodule

// File: rtl/phase_synth.sv
module phase_synth #(
  parameter int TUNE_W   = 10,
  parameter bit DECIMAL  = 1'b0,
  parameter int BIN_BITS = 20,
  parameter int DIGITS   = 6,
  localparam int ACC_W   = DECIMAL ? 4 * DIGITS : BIN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TUNE_W-1:0] tune_in,
  input  logic              tune_load,
  output logic              synth_out
);
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc_q;
  logic             acc_wrap;

  pas_tune_reg #(.TUNE_W(TUNE_W), .ACC_W(ACC_W), .DECIMAL(DECIMAL)) u_tune (
    .clk(clk), .rst(rst), .load(tune_load), .tune_in(tune_in), .addend(addend)
  );

  generate
    if (DECIMAL) begin : g_dec
      pas_dec_acc #(.DIGITS(DIGITS)) u_acc (
        .clk(clk), .rst(rst), .addend(addend), .acc(acc_q), .wrap(acc_wrap)
      );
      assign synth_out = (acc_q[ACC_W-1 -: 4] >= 4'd5);
    end else begin : g_bin
      pas_bin_acc #(.W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .addend(addend), .acc(acc_q), .wrap(acc_wrap)
      );
      assign synth_out = acc_q[ACC_W-1];
    end
  endgenerate
endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int TUNE_W  = 10,
  parameter int ACC_W   = 20,
  parameter bit DECIMAL = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [TUNE_W-1:0] tune_in,
  input logic              tune_load,
  input logic              synth_out,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  addend,
  input logic              acc_wrap
);
  localparam int     NDIG = ACC_W / 4;
  localparam longint DMOD = 10 ** NDIG;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !synth_out && addend == '0));

  assert_hold_word_R5: assert property (@(posedge clk) disable iff (rst)
    !tune_load |=> $stable(addend));

  assert_fall_on_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(synth_out)) |-> $past(acc_wrap));

  assert_low_after_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(acc_wrap)) |-> !synth_out);

  generate
    if (DECIMAL) begin : g_dec
      assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> pas_pkg::bcd_value(64'(acc_q)) ==
          (pas_pkg::bcd_value(64'($past(acc_q))) + pas_pkg::bcd_value(64'($past(addend)))) % DMOD);
      assert_word_take_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tune_load)) |->
          pas_pkg::bcd_value(64'(addend)) == longint'($past(tune_in)));
      for (genvar d = 0; d < NDIG; d++) begin : g_legal
        assert_digit_legal_R3: assert property (@(posedge clk) disable iff (rst)
          acc_q[4*d +: 4] <= 4'd9);
      end
    end else begin : g_bin
      assert_bin_step_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> acc_q == ACC_W'($past(acc_q) + $past(addend)));
      assert_word_take_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tune_load)) |-> addend == ACC_W'($past(tune_in)));
    end
  endgenerate
endmodule

bind phase_synth pas_checker #(.TUNE_W(TUNE_W), .ACC_W(ACC_W), .DECIMAL(DECIMAL)) u_chk (
  .clk(clk), .rst(rst), .tune_in(tune_in), .tune_load(tune_load),
  .synth_out(synth_out), .acc_q(acc_q), .addend(addend), .acc_wrap(acc_wrap)
);

// File: tb/phase_synth_bench.sv
module phase_synth_bench;
  localparam longint MOD_B = 64'd1 << 20;
  localparam longint MOD_D = 64'd1000000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] tune_in = '0;
  logic       tune_load = 1'b0;
  logic       out_b, out_d;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  longint acc_b = 0, acc_d = 0;
  int     tune_m = 0;
  int     rise_dut_b = 0, rise_mod_b = 0, rise_dut_d = 0, rise_mod_d = 0;
  logic   prev_db = 0, prev_mb = 0, prev_dd = 0, prev_md = 0;

  always #5 clk = ~clk;

  phase_synth u_phase_synth (
    .clk(clk), .rst(rst), .tune_in(tune_in), .tune_load(tune_load), .synth_out(out_b)
  );

  phase_synth #(.DECIMAL(1'b1), .DIGITS(6)) u_phase_synth_dec (
    .clk(clk), .rst(rst), .tune_in(tune_in), .tune_load(tune_load), .synth_out(out_d)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input string req, input string what, input longint got, input longint exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // One clock: advance the model at the edge, compare 2 ns later.
  task automatic step();
    logic mb, md;
    @(posedge clk);
    if (rst) begin
      acc_b = 0; acc_d = 0; tune_m = 0;
    end else begin
      acc_b = (acc_b + tune_m) % MOD_B;
      acc_d = (acc_d + tune_m) % MOD_D;
      if (tune_load) tune_m = int'(tune_in);
    end
    #2;
    mb = (acc_b >= MOD_B / 2);
    md = (acc_d >= MOD_D / 2);
    check(cur_req, "binary out", longint'(out_b), longint'(mb));
    check(cur_req, "decimal out", longint'(out_d), longint'(md));
    if (out_b && !prev_db) rise_dut_b++;
    if (mb && !prev_mb)    rise_mod_b++;
    if (out_d && !prev_dd) rise_dut_d++;
    if (md && !prev_md)    rise_mod_d++;
    prev_db = out_b; prev_mb = mb; prev_dd = out_d; prev_md = md;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load_word(input int w);
    tune_in = 10'(w); tune_load = 1'b1;
    step();
    tune_load = 1'b0;
  endtask

  initial begin
    #1_900_000;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    mismatched++;
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    run(3);
    check("R1", "binary low in reset", longint'(out_b), 0);
    check("R1", "decimal low in reset", longint'(out_d), 0);
    rst = 1'b0;

    // R8: no word loaded yet, output must stay low
    cur_req = "R8";
    tune_in = 10'd600;
    run(200);
    check("R8", "binary idle low", longint'(out_b), 0);
    check("R8", "decimal idle low", longint'(out_d), 0);

    // R2/R3: top of the range
    cur_req = "R2/R3";
    load_word(600);
    run(12000);

    // R4: retune mid-phase without clearing
    cur_req = "R4";
    load_word(24);
    run(6000);
    load_word(512);
    run(5000);

    // R5: tune_in wiggles with no load
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      tune_in = 10'((i * 37) % 1024);
      step();
    end

    // R6: decimal conversion of four-digit and boundary words
    cur_req = "R6";
    load_word(1000);
    run(4000);
    load_word(999);
    run(3000);
    load_word(1023);
    run(3000);

    // R7: edge count over a window at a fixed word
    cur_req = "R7";
    load_word(300);
    rise_dut_b = 0; rise_mod_b = 0; rise_dut_d = 0; rise_mod_d = 0;
    run(20000);
    check("R7", "binary rising edges", longint'(rise_dut_b), longint'(rise_mod_b));
    check("R7", "decimal rising edges", longint'(rise_dut_d), longint'(rise_mod_d));
    check("R7", "binary edges nonzero", longint'(rise_mod_b > 0), 1);

    // R1: reset mid-run, then R8 again
    cur_req = "R1";
    rst = 1'b1;
    step();
    check("R1", "binary low after reset", longint'(out_b), 0);
    check("R1", "decimal low after reset", longint'(out_d), 0);
    rst = 1'b0;
    cur_req = "R8";
    run(2000);
    check("R8", "binary low after reset idle", longint'(out_b), 0);

    summary();
    $finish;
  end
endmodule